// File: doc/BRIEF.md
# Dual-Clock FIFO with Strapped Read Mode

This block is a first-in first-out buffer between two independent clock domains. Writes are taken on the write clock and reads on the read clock. A strap input is sampled while the asynchronous master reset is held low, and its value picks one of two read behaviours for as long as the block stays out of reset.

In standard mode a word reaches the registered output only when the reader asks for it. The read-side flag is low while the buffer holds nothing, and the write-side flag is low while it is full. In fall-through mode the oldest stored word moves into the output register without being asked for. The read-side flag is then high while that register holds no valid word, and the write-side flag is high while the store is full.

Both pointers cross between the domains in Gray code through two-stage synchronizers. Each flag therefore clears a fixed two cycles of its own clock after the event on the other side. A half-full indication is computed on the write side from the fill level.

Top module: `dcfifo_strap`

## Requirements
- R1: While `mrs_n` is low, `mode_sel` = 0 selects standard mode and `mode_sel` = 1 selects fall-through mode. The choice holds until the next reset. Out of reset with nothing stored, `dout` is 0 and `half_full` is 0. In standard mode `rflag` is 0 and `wflag` is 1. In fall-through mode `rflag` is 1 and `wflag` is 0.
- R2: Words leave in the order they were written. In standard mode, a rising `rclk` edge with `ren_n` = 0, `rcs_n` = 0 and data stored loads the oldest word into `dout`.
- R3: A rising `rclk` edge with `ren_n` = 1 or `rcs_n` = 1 performs no read. In standard mode, and in fall-through mode while the output holds a valid word, `dout` keeps its value.
- R4: In standard mode `rflag` is low whenever no word is stored. A read request while empty leaves `dout` unchanged.
- R5: When DEPTH words are stored, the write-side full state is shown as `wflag` = 0 in standard mode and `wflag` = 1 in fall-through mode. A write request while full stores nothing.
- R6: While `wcs_n` is 1, a rising `wclk` edge stores nothing, whatever the value of `wen_n`.
- R7: In fall-through mode the first word written into an empty FIFO appears on `dout`, with `rflag` going to 0, after the third rising `rclk` edge following the write edge. It is not visible after the second edge, and no read request is needed.
- R8: In fall-through mode, the `rclk` edge that reads the last valid word sets `rflag` to 1 and leaves `dout` unchanged.
- R9: In standard mode, after a write into an empty FIFO, `rflag` is still 0 after the first following `rclk` edge and is 1 after the second.
- R10: After a read frees a slot in a full FIFO, `wflag` still shows full after the first following `wclk` edge and shows not-full after the second.
- R11: `half_full` is 1 while the write-side fill level exceeds DEPTH/2, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrs_n | input | 1 | Asynchronous master reset, active low |
| mode_sel | input | 1 | Mode strap sampled during reset: 0 standard, 1 fall-through |
| wen_n | input | 1 | Write enable, active low |
| wcs_n | input | 1 | Write chip select, active low |
| din | input | DW | Write data |
| ren_n | input | 1 | Read enable, active low |
| rcs_n | input | 1 | Read chip select, active low |
| dout | output | DW | Registered read data |
| rflag | output | 1 | Standard: low when empty. Fall-through: high when the output is not valid |
| wflag | output | 1 | Standard: low when full. Fall-through: high when full |
| half_full | output | 1 | High when more than DEPTH/2 words are stored |

## Verification
The bench builds the block with DW = 16 and AW = 3, giving a depth of eight. With that depth, the half-full threshold of more than four words and the full state are reached within a short table of writes, and a write attempted while full can be checked against the read order that follows. Both clocks run at the same rate with a fixed phase offset. This makes the two-edge flag latencies and the third-edge fall-through exact cycle counts that the bench samples between edges.

// File: rtl/dcfifo_strap.sv
module dcfifo_strap #(
  parameter int DW = 72,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrs_n,
  input  logic          mode_sel,
  input  logic          wen_n,
  input  logic          wcs_n,
  input  logic [DW-1:0] din,
  input  logic          ren_n,
  input  logic          rcs_n,
  output logic [DW-1:0] dout,
  output logic          rflag,
  output logic          wflag,
  output logic          half_full
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic          wmode;
  logic [PW-1:0] wbin, wgray, rg_s1, rg_s2;
  logic          full, wr_go;
  logic [PW-1:0] wbin_nx, fill;

  assign full    = (wgray == {~rg_s2[PW-1:PW-2], rg_s2[PW-3:0]});
  assign wr_go   = !wen_n && !wcs_n && !full;
  assign wbin_nx = wbin + 1'b1;
  assign fill    = wbin - g2b(rg_s2);

  always_ff @(posedge wclk or negedge mrs_n)
    if (!mrs_n) begin
      wmode <= mode_sel;
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_go) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end

  always_ff @(posedge wclk)
    if (wr_go) mem[wbin[AW-1:0]] <= din;

  assign wflag     = wmode ? full : !full;
  assign half_full = fill > PW'(DEPTH / 2);

  // read domain
  logic          rmode, dvalid;
  logic [PW-1:0] rbin, rgray, wg_s1, wg_s2;
  logic          empty, rd_req, pull;
  logic [PW-1:0] rbin_nx;

  assign empty   = (rgray == wg_s2);
  assign rd_req  = !ren_n && !rcs_n;
  assign pull    = !empty && (rmode ? (!dvalid || rd_req) : rd_req);
  assign rbin_nx = rbin + 1'b1;

  always_ff @(posedge rclk or negedge mrs_n)
    if (!mrs_n) begin
      rmode  <= mode_sel;
      rbin   <= '0;
      rgray  <= '0;
      wg_s1  <= '0;
      wg_s2  <= '0;
      dvalid <= 1'b0;
      dout   <= '0;
    end else begin
      wg_s1 <= wgray;
      wg_s2 <= wg_s1;
      if (pull) begin
        rbin   <= rbin_nx;
        rgray  <= rbin_nx ^ (rbin_nx >> 1);
        dout   <= mem[rbin[AW-1:0]];
        dvalid <= 1'b1;
      end else if (rd_req) begin
        dvalid <= 1'b0;
      end
    end

  assign rflag = rmode ? !dvalid : !empty;
endmodule

// File: rtl/dcfifo_strap_chk.sv
module dcfifo_strap_chk #(
  parameter int DW = 72,
  parameter int PW = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          mrs_n,
  input logic          wcs_n,
  input logic          ren_n,
  input logic          rcs_n,
  input logic [DW-1:0] dout,
  input logic          rflag,
  input logic          wflag,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic          wmode,
  input logic          rmode
);
  p_mode_hold_w_r1: assert property (@(posedge wclk) disable iff (!mrs_n) $stable(wmode));
  p_mode_hold_r_r1: assert property (@(posedge rclk) disable iff (!mrs_n) $stable(rmode));

  p_no_read_hold_r3: assert property (@(posedge rclk) disable iff (!mrs_n)
    (!rmode && (ren_n || rcs_n)) |=> $stable(dout));

  p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!mrs_n)
    (!rmode && !rflag) |=> ($stable(rbin) && $stable(dout)));

  p_no_overflow_r5: assert property (@(posedge wclk) disable iff (!mrs_n)
    (wmode ? wflag : !wflag) |=> $stable(wbin));

  p_cs_gate_r6: assert property (@(posedge wclk) disable iff (!mrs_n)
    wcs_n |=> $stable(wbin));

  p_fwft_keep_r8: assert property (@(posedge rclk) disable iff (!mrs_n)
    (rmode && !rflag && (ren_n || rcs_n)) |=> (!rflag && $stable(dout)));
endmodule

bind dcfifo_strap dcfifo_strap_chk #(.DW(DW), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .wcs_n(wcs_n), .ren_n(ren_n),
  .rcs_n(rcs_n), .dout(dout), .rflag(rflag), .wflag(wflag), .wbin(wbin),
  .rbin(rbin), .wmode(wmode), .rmode(rmode)
);

// File: tb/sim_dcfifo_strap.sv
module sim_dcfifo_strap;
  localparam int DW = 16;
  localparam int AW = 3;

  logic wclk, rclk, mrs_n, mode_sel, wen_n, wcs_n, ren_n, rcs_n;
  logic [DW-1:0] din, dout;
  logic rflag, wflag, half_full;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_q [16];
  int n_exp = 0;

  // {cs_n, data}: entries with cs_n = 1 must not be stored
  localparam logic [16:0] TBL [10] = '{
    17'h0_1111, 17'h1_BAD0, 17'h0_2222, 17'h0_3333, 17'h1_BAD1,
    17'h0_4444, 17'h0_5555, 17'h0_6666, 17'h1_BAD2, 17'h0_7777
  };

  dcfifo_strap #(.DW(DW), .AW(AW)) u0 (
    .wclk(wclk), .rclk(rclk), .mrs_n(mrs_n), .mode_sel(mode_sel),
    .wen_n(wen_n), .wcs_n(wcs_n), .din(din), .ren_n(ren_n), .rcs_n(rcs_n),
    .dout(dout), .rflag(rflag), .wflag(wflag), .half_full(half_full)
  );

  initial begin wclk = 0; forever #5 wclk = ~wclk; end
  initial begin rclk = 0; #3; forever #5 rclk = ~rclk; end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic m);
    @(negedge wclk);
    mode_sel = m; mrs_n = 0;
    wen_n = 1; wcs_n = 0; ren_n = 1; rcs_n = 0; din = '0;
    repeat (3) @(negedge wclk);
    mrs_n = 1;
    @(negedge wclk);
  endtask

  task automatic do_write(input logic [15:0] d, input logic cs);
    @(negedge wclk);
    wen_n = 0; wcs_n = cs; din = d;
    @(negedge wclk);
    wen_n = 1; wcs_n = 0;
  endtask

  task automatic do_read;
    @(negedge rclk);
    ren_n = 0; rcs_n = 0;
    @(negedge rclk);
    ren_n = 1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mrs_n = 0; mode_sel = 0; wen_n = 1; wcs_n = 0; ren_n = 1; rcs_n = 0; din = '0;

    // ---------------- standard mode ----------------
    do_reset(1'b0);
    chk(rflag == 0, "R1 std rflag", 32'(rflag), 0);
    chk(wflag == 1, "R1 std wflag", 32'(wflag), 1);
    chk(half_full == 0, "R1 half_full", 32'(half_full), 0);
    chk(dout == 0, "R1 dout", 32'(dout), 0);

    for (int i = 0; i < 10; i++) begin
      do_write(TBL[i][15:0], TBL[i][16]);
      if (!TBL[i][16]) begin exp_q[n_exp] = TBL[i][15:0]; n_exp++; end
    end
    repeat (3) @(negedge wclk);
    chk(wflag == 1, "R5 not full at 7", 32'(wflag), 1);
    chk(half_full == 1, "R11 above half", 32'(half_full), 1);

    repeat (3) @(negedge rclk);
    chk(rflag == 1, "R4 not empty", 32'(rflag), 1);
    @(negedge rclk); ren_n = 0; rcs_n = 1;
    @(negedge rclk); ren_n = 1; rcs_n = 0;
    chk(dout == 0, "R3 rcs_n high no read", 32'(dout), 0);

    do_write(16'h8888, 1'b0); exp_q[n_exp] = 16'h8888; n_exp++;
    repeat (2) @(negedge wclk);
    chk(wflag == 0, "R5 full", 32'(wflag), 0);
    do_write(16'hDEAD, 1'b0);

    do_read;
    chk(dout == exp_q[0], "R2 first word", 32'(dout), 32'(exp_q[0]));
    @(negedge wclk);
    chk(wflag == 0, "R10 still full after 1 edge", 32'(wflag), 0);
    @(negedge wclk);
    chk(wflag == 1, "R10 not full after 2 edges", 32'(wflag), 1);

    for (int i = 1; i < n_exp; i++) begin
      do_read;
      chk(dout == exp_q[i], "R2 R6 R5 order", 32'(dout), 32'(exp_q[i]));
    end
    repeat (3) @(negedge rclk);
    chk(rflag == 0, "R4 empty", 32'(rflag), 0);
    do_read;
    chk(dout == 16'h8888, "R4 read while empty", 32'(dout), 32'h8888);
    repeat (4) @(negedge wclk);
    chk(half_full == 0, "R11 drained", 32'(half_full), 0);

    do_write(16'h5A5A, 1'b0);
    @(negedge rclk);
    chk(rflag == 0, "R9 after 1 rclk edge", 32'(rflag), 0);
    @(negedge rclk);
    chk(rflag == 1, "R9 after 2 rclk edges", 32'(rflag), 1);
    do_read;
    chk(dout == 16'h5A5A, "R2 single word", 32'(dout), 32'h5A5A);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    chk(rflag == 1, "R1 fwft rflag", 32'(rflag), 1);
    chk(wflag == 0, "R1 fwft wflag", 32'(wflag), 0);
    chk(dout == 0, "R1 fwft dout", 32'(dout), 0);

    do_write(16'h1234, 1'b0);
    @(negedge rclk);
    @(negedge rclk);
    chk(rflag == 1 && dout == 0, "R7 not yet after 2 edges", {15'd0, rflag, dout}, 32'h0001_0000);
    @(negedge rclk);
    chk(rflag == 0 && dout == 16'h1234, "R7 fell through on 3rd edge", {15'd0, rflag, dout}, 32'h0000_1234);
    do_read;
    chk(rflag == 1, "R8 last word read", 32'(rflag), 1);
    chk(dout == 16'h1234, "R8 dout kept", 32'(dout), 32'h1234);

    for (int i = 0; i < 9; i++) do_write(16'hA000 + 16'(i), 1'b0);
    repeat (3) @(negedge wclk);
    chk(wflag == 1, "R5 fwft full", 32'(wflag), 1);
    do_write(16'hBEEF, 1'b0);
    repeat (3) @(negedge rclk);
    @(negedge rclk); ren_n = 1; rcs_n = 0;
    @(negedge rclk); ren_n = 0; rcs_n = 1;
    @(negedge rclk); ren_n = 1; rcs_n = 0;
    chk(dout == 16'hA000 && rflag == 0, "R3 fwft hold", {15'd0, rflag, dout}, 32'h0000_A000);

    for (int i = 0; i < 9; i++) begin
      chk(dout == 16'hA000 + 16'(i), "R2 fwft order", 32'(dout), 32'(16'hA000 + 16'(i)));
      do_read;
    end
    repeat (3) @(negedge rclk);
    chk(rflag == 1, "R8 R5 drained, full write dropped", 32'(rflag), 1);
    chk(dout == 16'hA008, "R8 dout kept after last", 32'(dout), 32'hA008);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule